// File: doc/BRIEF.md
# Multi-Channel Output-Compare Timer

The block runs one 16-bit up-counter that eight compare channels share. The count source can be stopped, or taken from the system clock, from a fixed-rate enable pulse or from an external enable pulse. A power-of-two prescaler divides the chosen source by a factor from 1 to 128. The counter climbs from a programmable start value to a programmable wrap limit, then reloads the start value.

Each channel has its own compare value and a status/control word. When a channel is in compare mode and the counter matches its compare value on a prescaled tick, the channel sets a sticky event flag. An event flag with its enable set drives the shared interrupt line. Software reschedules an event by writing a tick offset to the channel's advance address. The block adds the offset to the compare value modulo 2^16, so both the event spacing and the period can vary freely.

All setup goes through a plain register port: address, write data, write strobe, read strobe and combinational read data. A lock bit guards the timebase setup. None of the registers is a data stream, so the port has no handshake: a write takes effect at the clock edge where its strobe is high.

Top module: `otc_timer`

Register layout (6-bit address, 16-bit data):
- 0x00 timebase: [1:0] source (00 stopped, 01 system clock, 10 fixed-rate pulse, 11 external pulse), [4:2] prescale code N (divide by 2^N). Locked.
- 0x01 counter: reads the count. Any write loads the start value.
- 0x02 wrap limit, reset value 0xFFFF. Locked.
- 0x03 start value, reset value 0x0000. Locked.
- 0x04 control: [0] unlock (1 = locked registers writable), [1] run.
- 0x10+2c channel c status: [0] event flag, [1] interrupt enable, [3:2] mode pair {hi,lo}.
- 0x11+2c channel c compare value.
- 0x20+c channel c advance: a write adds its data to the compare value; a read returns the compare value.

## Requirements
- R1: After reset the count, start value, timebase, control and all channel words read 0, the wrap limit reads 0xFFFF and irq is low.
- R2: The counter advances only while run is 1. Source 00 never advances it, 01 advances it on every clock, 10 on each clock where fixed_tick is high and 11 on each clock where ext_tick is high.
- R3: With prescale code N the counter advances once per 2^N source pulses. Code 0 divides by 1 and code 7 divides by 128, and two ticks never fall in consecutive source pulses when N is above 0.
- R4: A tick taken while the count equals the wrap limit loads the start value, so the count runs start, start+1, ..., limit, start.
- R5: A write to the counter address loads the start value at that edge, whatever the lock bit is, and takes priority over a tick.
- R6: While the unlock bit is 0, writes to the timebase, wrap limit and start value are ignored.
- R7: A channel whose mode pair is 01 sets its event flag at the first clock edge where a tick occurs while the count equals its compare value, so the flag reads 1 one cycle after the count reaches that value at prescale 1. Any other mode pair never sets the flag.
- R8: An event flag clears only on a status write with bit 0 = 0, made after a status read that returned the flag as 1 and with no status write in between. Any status write disarms the clear.
- R9: When a clearing status write and a new match for the same channel land on the same edge, the flag stays 1.
- R10: irq is high exactly when some channel has both its event flag and its interrupt enable set.
- R11: A write to a channel's advance address sets its compare value to the old value plus the written offset, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| fixed_tick | input | 1 | Fixed-rate count enable pulse, synchronous to clk |
| ext_tick | input | 1 | External count enable pulse, already synchronised to clk |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe; arms the flag clear of a status word that reads as 1 |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench checks when the event flag appears, relative to the count reaching the compare value. A design that compared the count every clock, or one register later, would show the flag a cycle early or late. A design that lost the dwell rule would fire again while the count is held. The bench also lands a clearing write and a fresh match on the same edge; a design that let the clear win would lose that event. Further checks cover a clearing write made without a prior read, wrap to a non-zero start value, the divide-by-128 end of the prescaler, and an advance that wraps past 0xFFFF. These catch an unarmed clear, a wrap to zero, an off-by-one divider and a saturating adder.

// File: rtl/otc_pkg.sv
package otc_pkg;
  localparam int CW   = 16;  // counter and data width
  localparam int NCH  = 8;   // compare channels
  localparam int DIVW = 3;   // prescale code width
  localparam int AW   = 6;   // register address width

  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_SYS   = 2'b01,
    SRC_FIXED = 2'b10,
    SRC_EXT   = 2'b11
  } src_e;

  localparam logic [1:0] MODE_COMPARE = 2'b01;

  localparam int A_TBASE     = 0;
  localparam int A_COUNT     = 1;
  localparam int A_LIMIT     = 2;
  localparam int A_START     = 3;
  localparam int A_CTRL      = 4;
  localparam int A_STAT_BASE = 16;
  localparam int A_ADV_BASE  = 32;
endpackage

// File: rtl/otc_prescaler.sv
module otc_prescaler
  import otc_pkg::*;
#(
  parameter int DIV_W = DIVW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  src_e             src_sel,
  input  logic [DIV_W-1:0] div,
  input  logic             fixed_tick,
  input  logic             ext_tick,
  input  logic             clr,
  output logic             tick
);
  localparam int PW = (1 << DIV_W) - 1;

  logic [PW-1:0] pre;
  logic [PW-1:0] mask;
  logic          src_en;

  always_comb begin
    unique case (src_sel)
      SRC_SYS:   src_en = run;
      SRC_FIXED: src_en = run & fixed_tick;
      SRC_EXT:   src_en = run & ext_tick;
      default:   src_en = 1'b0;
    endcase
    mask = ~({PW{1'b1}} << div);
    tick = src_en && ((pre & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pre <= '0;
    else if (clr)    pre <= '0;
    else if (src_en) pre <= pre + 1'b1;
  end

  // R3: above divide-by-1, a tick is never followed by another on the next edge
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/otc_counter.sv
module otc_counter
  import otc_pkg::*;
#(
  parameter int W = CW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] start,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= start;
    else if (tick) count <= (count == limit) ? start : count + 1'b1;
  end

  // R5: a counter write reloads the start value
  a_r5_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(start));

  // R4: a tick at the wrap limit returns to the start value
  a_r4_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && count == limit) |=> count == $past(start));
endmodule

// File: rtl/otc_channel.sv
module otc_channel
  import otc_pkg::*;
#(
  parameter int W = CW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic         wr_stat,
  input  logic         rd_stat,
  input  logic         wr_cmp,
  input  logic         wr_adv,
  input  logic [W-1:0] wdata,
  output logic [3:0]   stat,
  output logic [W-1:0] cmp,
  output logic         req
);
  logic       flag;
  logic       ie;
  logic [1:0] mode;
  logic       armed;
  logic       hit;

  assign hit  = tick && (mode == MODE_COMPARE) && (count == cmp);
  assign stat = {mode, ie, flag};
  assign req  = flag & ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
      ie    <= 1'b0;
      mode  <= 2'b00;
    end else begin
      if (hit)                              flag <= 1'b1;
      else if (wr_stat && armed && !wdata[0]) flag <= 1'b0;
      if (wr_stat) begin
        armed <= 1'b0;
        ie    <= wdata[1];
        mode  <= wdata[3:2];
      end else if (rd_stat) begin
        armed <= flag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp <= '0;
    else if (wr_cmp) cmp <= wdata;
    else if (wr_adv) cmp <= cmp + wdata;
  end

  // R7: the flag only rises after a tick that met the compare value in compare mode
  a_r7_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick && count == cmp && mode == MODE_COMPARE));

  // R8: the flag only falls after an armed status write
  a_r8_clear_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed && wr_stat && !wdata[0]));

  // R9: a match always leaves the flag set, even against a clear
  a_r9_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
endmodule

// File: rtl/otc_timer.sv
module otc_timer
  import otc_pkg::*;
#(
  parameter int W      = CW,
  parameter int N_CH   = NCH,
  parameter int DIV_BW = DIVW,
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fixed_tick,
  input  logic              ext_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [W-1:0]      reg_rdata,
  output logic              irq
);
  logic              unlock, run;
  src_e              src;
  logic [DIV_BW-1:0] div;
  logic [W-1:0]      limit, start, count;
  logic              tick, cnt_load;
  logic [3:0]        stat_q [N_CH];
  logic [W-1:0]      cmp_q  [N_CH];
  logic [N_CH-1:0]   req;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int v);
    return a == ADDR_W'(v);
  endfunction

  assign cnt_load = reg_we && at(reg_addr, A_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlock <= 1'b0;
      run    <= 1'b0;
      src    <= SRC_OFF;
      div    <= '0;
      limit  <= '1;
      start  <= '0;
    end else if (reg_we) begin
      if (at(reg_addr, A_CTRL)) begin
        unlock <= reg_wdata[0];
        run    <= reg_wdata[1];
      end
      if (unlock && at(reg_addr, A_TBASE)) begin
        src <= src_e'(reg_wdata[1:0]);
        div <= reg_wdata[2 +: DIV_BW];
      end
      if (unlock && at(reg_addr, A_LIMIT)) limit <= reg_wdata;
      if (unlock && at(reg_addr, A_START)) start <= reg_wdata;
    end
  end

  otc_prescaler #(.DIV_W(DIV_BW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src), .div(div),
    .fixed_tick(fixed_tick), .ext_tick(ext_tick), .clr(cnt_load), .tick(tick)
  );

  otc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
    .start(start), .limit(limit), .count(count)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    otc_channel #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick), .count(count),
      .wr_stat(reg_we && at(reg_addr, A_STAT_BASE + 2 * g)),
      .rd_stat(reg_re && at(reg_addr, A_STAT_BASE + 2 * g)),
      .wr_cmp (reg_we && at(reg_addr, A_STAT_BASE + 2 * g + 1)),
      .wr_adv (reg_we && at(reg_addr, A_ADV_BASE + g)),
      .wdata(reg_wdata), .stat(stat_q[g]), .cmp(cmp_q[g]), .req(req[g])
    );
  end

  assign irq = |req;

  always_comb begin
    reg_rdata = '0;
    if (at(reg_addr, A_TBASE)) begin
      reg_rdata[1:0]         = src;
      reg_rdata[2 +: DIV_BW] = div;
    end
    if (at(reg_addr, A_COUNT)) reg_rdata = count;
    if (at(reg_addr, A_LIMIT)) reg_rdata = limit;
    if (at(reg_addr, A_START)) reg_rdata = start;
    if (at(reg_addr, A_CTRL))  reg_rdata[1:0] = {run, unlock};
    for (int i = 0; i < N_CH; i++) begin
      if (at(reg_addr, A_STAT_BASE + 2 * i))     reg_rdata[3:0] = stat_q[i];
      if (at(reg_addr, A_STAT_BASE + 2 * i + 1)) reg_rdata = cmp_q[i];
      if (at(reg_addr, A_ADV_BASE + i))          reg_rdata = cmp_q[i];
    end
  end

  // R6: locked setup registers hold through a write attempt
  a_r6_locked_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !unlock) |=> ($stable(src) && $stable(div) && $stable(limit) && $stable(start)));
endmodule

// File: tb/otc_timer_tb.sv
module otc_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fixed_tick = 1'b0;
  logic        ext_tick = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;

  localparam logic [5:0] TBASE = 6'h00, COUNT = 6'h01, LIMIT = 6'h02,
                         START = 6'h03, CTRL = 6'h04;

  always #2.5 clk = ~clk;
  always @(negedge clk) fixed_tick <= ~fixed_tick;

  otc_timer u_dut (
    .clk(clk), .rst_n(rst_n), .fixed_tick(fixed_tick), .ext_tick(ext_tick),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [5:0] st(input int c);  return 6'(16 + 2 * c);     endfunction
  function automatic logic [5:0] cv(input int c);  return 6'(17 + 2 * c);     endfunction
  function automatic logic [5:0] adv(input int c); return 6'(32 + c);         endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    reg_addr = a; reg_re = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_re = 1'b0;
  endtask

  // count advance across n clock edges
  task automatic measure(input int n, output logic [15:0] d);
    logic [15:0] a, b;
    rd(COUNT, a);
    idle(n - 1);
    rd(COUNT, b);
    d = b - a;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(COUNT, v);  check("R1 count", v, 16'h0000);
    rd(LIMIT, v);  check("R1 limit", v, 16'hFFFF);
    rd(START, v);  check("R1 start", v, 16'h0000);
    rd(TBASE, v);  check("R1 timebase", v, 16'h0000);
    rd(CTRL, v);   check("R1 control", v, 16'h0000);
    rd(st(0), v);  check("R1 status", v, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_sources();
    logic [15:0] d;
    wr(CTRL, 16'h0001);
    wr(TBASE, 16'h0001);
    measure(64, d); check("R2 run off", d, 16'd0);
    wr(CTRL, 16'h0003);
    measure(64, d); check("R2 system clock", d, 16'd64);
    wr(TBASE, 16'h0002);
    measure(64, d); check("R2 fixed pulse", d, 16'd32);
    wr(TBASE, 16'h0003);
    measure(64, d); check("R2 external idle", d, 16'd0);
    wr(TBASE, 16'h0000);
    measure(64, d); check("R2 stopped", d, 16'd0);
    wr(TBASE, 16'h0009);
    measure(64, d); check("R3 divide by 4", d, 16'd16);
    wr(TBASE, 16'h001D);
    measure(256, d); check("R3 divide by 128", d, 16'd2);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wr(START, 16'h0010);
    wr(LIMIT, 16'h0013);
    wr(TBASE, 16'h0001);
    wr(COUNT, 16'hABCD);
    rd(COUNT, v); check("R5 load start", v, 16'h0010);
    rd(COUNT, v); check("R4 step", v, 16'h0011);
    rd(COUNT, v); check("R4 step", v, 16'h0012);
    rd(COUNT, v); check("R4 at limit", v, 16'h0013);
    rd(COUNT, v); check("R4 wrap to start", v, 16'h0010);
  endtask

  task automatic t_lock();
    logic [15:0] a, b;
    wr(CTRL, 16'h0002);
    wr(LIMIT, 16'h0005);
    rd(LIMIT, a); check("R6 limit locked", a, 16'h0013);
    wr(START, 16'h0001);
    rd(START, a); check("R6 start locked", a, 16'h0010);
    wr(TBASE, 16'h0000);
    rd(COUNT, a); rd(COUNT, b);
    check("R6 timebase locked, still counting", {15'b0, a != b}, 16'h0001);
  endtask

  task automatic t_match();
    logic [15:0] v;
    wr(CTRL, 16'h0003);
    wr(START, 16'h0000);
    wr(LIMIT, 16'hFFFF);
    wr(TBASE, 16'h0001);
    wr(st(0), 16'h0006); wr(cv(0), 16'h0040);
    wr(st(1), 16'h000E); wr(cv(1), 16'h0040);
    wr(st(2), 16'h0004); wr(cv(2), 16'h0040);
    wr(COUNT, 16'h0000);
    idle(64);
    rd(st(0), v); check("R7 no flag while count reaches value", v, 16'h0006);
    rd(st(0), v); check("R7 flag one cycle later", v, 16'h0007);
    rd(st(1), v); check("R7 other mode never flags", v, 16'h000E);
    rd(st(2), v); check("R7 flag without enable", v, 16'h0005);
    check("R10 irq from enabled flag", {15'b0, irq}, 16'h0001);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(st(0), 16'h0007);
    wr(st(0), 16'h0006);
    rd(st(0), v); check("R8 unarmed write keeps flag", v, 16'h0007);
    wr(st(0), 16'h0006);
    rd(st(0), v); check("R8 armed clear", v, 16'h0006);
    check("R10 irq low with only disabled flag", {15'b0, irq}, 16'h0000);
    wr(st(2), 16'h0007);
    check("R10 irq after enabling flagged channel", {15'b0, irq}, 16'h0001);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    wr(TBASE, 16'h0003);
    wr(st(3), 16'h0004);
    wr(cv(3), 16'h0000);
    wr(COUNT, 16'h0000);
    ext_tick = 1'b1; @(posedge clk); @(negedge clk); ext_tick = 1'b0;
    wr(cv(3), 16'h0001);
    rd(st(3), v); check("R9 first match", v, 16'h0005);
    reg_addr = st(3); reg_wdata = 16'h0004; reg_we = 1'b1; ext_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0; ext_tick = 1'b0;
    rd(st(3), v); check("R9 match beats clear", v, 16'h0005);
    rd(COUNT, v); check("R2 external pulses counted", v, 16'h0002);
  endtask

  task automatic t_advance();
    logic [15:0] v;
    wr(cv(4), 16'hFFF0);
    wr(adv(4), 16'h0020);
    rd(cv(4), v); check("R11 advance wraps", v, 16'h0010);
    wr(adv(4), 16'h0001);
    rd(adv(4), v); check("R11 advance adds", v, 16'h0011);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0001, 16'h0000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sources();
    t_wrap();
    t_lock();
    t_match();
    t_clear();
    t_collide();
    t_advance();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule